// File: doc/BRIEF.md
# Bit-Serial Word Adder

This block adds two full-width words using nothing but one single-bit full adder and a carry flip-flop. It is a drop-in replacement for a parallel adder in a word-wide datapath where area and leakage matter more than latency. The surrounding logic still sees parallel words: it presents both operands and pulses a start strobe, and some cycles later it reads a parallel sum and a carry-out.

On an accepted start, both operands are captured into shift registers and the carry flip-flop is cleared. On each following clock, the lowest bit of each operand register goes through the full adder together with the stored carry. The sum bit enters the result register at its most significant end, and the carry flip-flop takes the new carry. After one cycle per bit, the result register holds the sum in natural bit order and a one-cycle completion pulse is raised. The result and the carry stay unchanged until the next accepted start. A start that arrives while an addition is running is dropped.

Top module: `serial_word_adder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `sum` is all zeros and `carry_out` and `done` are 0.
- R2: With WIDTH = 32, `sum` equals (a + b) mod 2^32 when `done` is high, where a and b are the `opa` and `opb` values sampled on the accepted start edge.
- R3: When `done` is high, `carry_out` equals bit 32 of the 33-bit sum a + b.
- R4: `start` is accepted on a rising edge when no addition is running. `done` goes high after the 32nd rising edge that follows the accepting edge, and it stays high for exactly one cycle.
- R5: A `start` during a running addition is ignored. Neither the result nor the timing of `done` changes.
- R6: Each accepted start clears the carry flip-flop, so a carry from an earlier addition has no effect on the next one.
- R7: While no addition is running and `start` is low, `sum` and `carry_out` stay constant, whatever `opa` and `opb` do.
- R8: A `start` in the cycle where `done` is high is accepted, and the next result follows R4 timing from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| start | input | 1 | Load strobe: captures both operands when idle |
| opa | input | WIDTH | First operand, parallel |
| opb | input | WIDTH | Second operand, parallel |
| sum | output | WIDTH | Parallel sum, valid from `done` until the next accepted start |
| carry_out | output | 1 | Carry out of the most significant bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench first checks carries that ripple across the whole word: all-ones plus one, and two values with only the top bit set. A wrong carry path would drop the carry or deliver it one bit late, and the wrong sum or carry-out would show. Right after an addition that ends with a carry, it runs zero plus zero. If the carry flip-flop were not cleared on load, this result would read as one. It counts cycles to the completion pulse exactly, including a start that arrives in the cycle the pulse is high. An off-by-one counter or a pulse longer than one cycle would fail these counts. A start in the middle of an addition, and operand changes while idle, check that a design that reloads or keeps shifting does not corrupt the held result.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_t;
endpackage

// File: rtl/sadd_full_adder.sv
module sadd_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  always_comb begin
    s_o = x_i ^ y_i ^ c_i;
    c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
  end
endmodule

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (load_en)       q_n = load_val;
    else if (shift_en) q_n = {ser_in, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/sadd_sequencer.sv
module sadd_sequencer
  import sadd_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic run_en,
  output logic done
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  sq_state_t        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic             last_bit;

  assign run_en   = (st_q == SQ_RUN);
  assign load_en  = start && (st_q == SQ_IDLE);
  assign last_bit = run_en && (cnt_q == LAST);
  assign done     = done_q;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (load_en) begin
      st_n  = SQ_RUN;
      cnt_n = '0;
    end else if (run_en) begin
      cnt_n = cnt_q + 1'b1;
      if (last_bit) begin
        st_n   = SQ_IDLE;
        cnt_n  = '0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end
endmodule

// File: rtl/serial_word_adder.sv
module serial_word_adder #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             done
);
  logic             load_en, run_en;
  logic [WIDTH-1:0] a_sh, b_sh;
  logic             fa_s, fa_c;
  logic             cy_q, cy_n;

  sadd_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load_en(load_en), .run_en(run_en), .done(done)
  );

  sadd_shreg #(.W(WIDTH)) u_opa (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(opa),
    .shift_en(run_en), .ser_in(1'b0), .q(a_sh)
  );

  sadd_shreg #(.W(WIDTH)) u_opb (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(opb),
    .shift_en(run_en), .ser_in(1'b0), .q(b_sh)
  );

  sadd_full_adder u_fa (
    .x_i(a_sh[0]), .y_i(b_sh[0]), .c_i(cy_q), .s_o(fa_s), .c_o(fa_c)
  );

  // result register: new bits enter at the top, so bit 0 settles at 0
  sadd_shreg #(.W(WIDTH)) u_res (
    .clk(clk), .rst_n(rst_n), .load_en(1'b0), .load_val({WIDTH{1'b0}}),
    .shift_en(run_en), .ser_in(fa_s), .q(sum)
  );

  always_comb begin
    cy_n = cy_q;
    if (load_en)     cy_n = 1'b0;
    else if (run_en) cy_n = fa_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cy_q <= 1'b0;
    else        cy_q <= cy_n;
  end

  assign carry_out = cy_q;
endmodule

// File: rtl/sadd_checker.sv
module sadd_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic             done,
  input logic             busy
);
  localparam int CW = $clog2(WIDTH + 2) + 1;
  logic [CW-1:0] since_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_load <= '1;
    else if (start && !busy)            since_load <= '0;
    else if (since_load != {CW{1'b1}})  since_load <= since_load + 1'b1;
  end

  // R4 / R5: pulse lands exactly WIDTH edges after the accepting edge
  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_load == CW'(WIDTH)));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  // R6: the carry is zero in the first cycle of every addition
  a_r6_carry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (carry_out == 1'b0));

  // R7: idle without start keeps the result
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum) && $stable(carry_out)));

  // R5: start during a run does not end the run early
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
endmodule

bind serial_word_adder sadd_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sum(sum),
  .carry_out(carry_out), .done(done), .busy(run_en)
);

// File: tb/serial_word_adder_test.sv
module serial_word_adder_test;
  localparam int  W      = 32;
  localparam time PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] opa, opb;
  logic [W-1:0] sum;
  logic         carry_out, done;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  serial_word_adder #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .sum(sum), .carry_out(carry_out), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [W-1:0] a, input logic [W-1:0] b);
    start = 1'b1; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits from the negedge after the accepting edge; ends on the negedge with done high
  task automatic wait_done(input string req);
    for (int i = 1; i < W; i++) begin
      chk(req, done, 0);
      @(negedge clk);
    end
    chk(req, done, 0);
    @(negedge clk);
    chk(req, done, 1);
  endtask

  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    pulse_start(a, b);
    wait_done("R4");
    chk("R2", sum, exp[W-1:0]);
    chk("R3", carry_out, exp[W]);
    @(negedge clk);
    chk("R4 pulse width", done, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; opa = '1; opb = '1;
    repeat (3) @(negedge clk);
    chk("R1 sum", sum, 0);
    chk("R1 carry", carry_out, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sum after release", sum, 0);
    chk("R1 done after release", done, 0);
  endtask

  task automatic t_patterns();
    run_add(32'h1234_5678, 32'h1111_1111);
    run_add(32'hFFFF_FFFF, 32'h0000_0001);
    run_add(32'h8000_0000, 32'h8000_0000);
    run_add(32'hAAAA_AAAA, 32'h5555_5555);
    run_add(32'hDEAD_BEEF, 32'hCAFE_F00D);
  endtask

  task automatic t_carry_clear();  // R6
    run_add(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_add(32'h0, 32'h0);
    chk("R6 sum after carry", sum, 0);
    chk("R6 carry after carry", carry_out, 0);
  endtask

  task automatic t_ignore_start();  // R5
    pulse_start(32'h0000_00FF, 32'h0000_0001);
    for (int i = 1; i < 10; i++) begin
      chk("R5", done, 0);
      @(negedge clk);
    end
    start = 1'b1; opa = 32'h7000_0000; opb = 32'h7000_0000;
    @(negedge clk);
    start = 1'b0;
    for (int i = 11; i < W; i++) begin
      chk("R5 timing", done, 0);
      @(negedge clk);
    end
    chk("R5 timing", done, 0);
    @(negedge clk);
    chk("R5 timing", done, 1);
    chk("R5 sum", sum, 32'h0000_0100);
    chk("R5 carry", carry_out, 0);
    @(negedge clk);
  endtask

  task automatic t_hold();  // R7
    logic [W:0] exp;
    run_add(32'hF000_0001, 32'h2000_0002);
    exp = {1'b0, 32'hF000_0001} + {1'b0, 32'h2000_0002};
    for (int i = 0; i < 6; i++) begin
      opa = 32'h0101_0101 * i; opb = ~opa;
      @(negedge clk);
      chk("R7 sum", sum, exp[W-1:0]);
      chk("R7 carry", carry_out, exp[W]);
      chk("R7 done", done, 0);
    end
  endtask

  task automatic t_back_to_back();  // R8
    logic [W:0] exp;
    pulse_start(32'h0000_0003, 32'h0000_0004);
    wait_done("R8 first");
    chk("R8 first sum", sum, 7);
    exp = {1'b0, 32'hFFFF_0000} + {1'b0, 32'h0001_0000};
    pulse_start(32'hFFFF_0000, 32'h0001_0000);
    wait_done("R8 second timing");
    chk("R8 second sum", sum, exp[W-1:0]);
    chk("R8 second carry", carry_out, exp[W]);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_patterns();
    t_carry_clear();
    t_ignore_start();
    t_hold();
    t_back_to_back();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule